// File: doc/BRIEF.md
# PCI Error Capture and Reporting

This block sits in a host bridge and turns error events seen on the PCI side into sticky status bits. It can also drive an active-low system-error strobe onto the bus and send a single-cycle machine-check request to the processor. It takes the following inputs:

- detected address-parity and data-parity strobes
- the sampled system-error line of other agents
- a strobe marking the bridge's own address phase while it is initiator
- the PCI address of the current transaction
- a non-maskable error strobe

Recording is independent of reporting. The parity-seen status bit is always set. Bus signalling and processor notification are each gated by their own enables.

Software reaches the registers through a small write port and a combinational read port selected by `cfg_sel`. The encoding is: 0 command, 1 bus status, 2 enable A, 3 enable B, 4 detect A, 5 detect B, 6 captured error address (read only). Status and detect registers are write-1-to-clear. The captured address holds the first reported PCI error and stays frozen until the detect-A bits are cleared. An external system error is charged to the bridge only when it is sampled exactly `SERR_LAG` (default 2) clocks after the bridge's own address phase.

Top module: `pci_err_report`

## Requirements
- R1: An `addr_par_err` or `data_par_err` strobe sets status bit 15 (selector 1) on the next edge, whatever the command register holds.
- R2: An `addr_par_err` strobe drives `serr_n` low for exactly the next clock, but only when command bits 6 and 8 (selector 0) are both 1. Otherwise `serr_n` stays high.
- R3: Each clock in which the block drives `serr_n` low, status bit 14 is set.
- R4: An `addr_par_err` strobe with command bit 6 and enable-B bit 7 (selector 3) both set sets detect-A bit 6 (selector 4) and requests a machine check.
- R5: With enable-A bit 7 (selector 2) set, `ext_serr_n` sampled low exactly 2 edges after the edge that sampled `own_addr_phase` sets detect-A bit 7 and requests a machine check. Sampling it low 1 or 3 edges after has no effect.
- R6: A machine-check request appears on `mc_req` as a one-clock pulse, the clock after the event, and only when `mc_en` was high at the event.
- R7: When detect-A bits 7, 6 and 5 are all clear, a reported PCI error (R4 or R5) captures its PCI address into selector 6 and clears detect-B bit 7 (address valid). The address is the current `pci_addr` for R4, or the address-phase address for R5.
- R8: An `nmi_err` strobe sets detect-A bit 5. If no error is held, it also sets detect-B bit 7 (address invalid) and leaves the captured address unchanged.
- R9: While any of detect-A bits 7, 6 or 5 is set, later errors do not change the captured address. Writing 1s to detect-A releases it.
- R10: Status and detect registers clear bits written as 1. A hardware set in the same clock as a clearing write wins.
- R11: When an attributed external error (R5) and a reportable address-parity error (R4) fall in the same clock, both detect-A bits set, the external error's address is captured, and `mc_req` pulses once.
- R12: After reset all registers read 0, `serr_n` is 1 and `mc_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register selector for read and write |
| cfg_wdata | input | 16 | Write data (1s clear in status and detect registers) |
| cfg_rdata | output | ADDR_W | Combinational read data of the selected register |
| addr_par_err | input | 1 | Address parity error detected this clock |
| data_par_err | input | 1 | Data parity error detected this clock |
| ext_serr_n | input | 1 | Sampled system-error line of other agents, active low |
| own_addr_phase | input | 1 | Bridge drives an address phase as initiator this clock |
| pci_addr | input | ADDR_W | PCI address of the current transaction |
| nmi_err | input | 1 | Non-maskable error strobe |
| mc_en | input | 1 | Global machine-check enable |
| serr_n | output | 1 | System-error strobe driven by the bridge, active low |
| mc_req | output | 1 | Machine-check request pulse to the processor |

## Verification
Two reporting paths can fire in the same clock: an address-parity error on the current transaction and an external system error aimed at an older address phase. Both want the single address capture and the single machine-check pulse. The bench starts an address phase, then raises the parity strobe with a different address on the very clock the external error is sampled. It checks that both detect-A bits set, that the older address wins the capture, and that `mc_req` is high for one clock only. A second collision puts a clearing write and a hardware set on the same edge, and the bit must stay set.

// File: rtl/pci_err_pkg.sv
package pci_err_pkg;

  localparam int REG_W = 16;

  // command register bits
  localparam int CMD_PAR_RESP = 6;
  localparam int CMD_SERR_EN  = 8;
  // bus status register bits
  localparam int STS_SIG_SERR = 14;
  localparam int STS_DET_PAR  = 15;
  // enable registers
  localparam int ENA_EXT_SERR = 7;
  localparam int ENB_APAR     = 7;
  // detect registers
  localparam int DETA_EXT_SERR = 7;
  localparam int DETA_APAR     = 6;
  localparam int DETA_NMI      = 5;
  localparam int DETB_ADDR_BAD = 7;

  typedef enum logic [2:0] {
    REG_CMD   = 3'd0,
    REG_STS   = 3'd1,
    REG_ENA   = 3'd2,
    REG_ENB   = 3'd3,
    REG_DETA  = 3'd4,
    REG_DETB  = 3'd5,
    REG_EADDR = 3'd6
  } reg_sel_e;

  typedef struct packed {
    logic par_seen;
    logic serr_drive;
    logic apar_report;
    logic ext_attr;
    logic nmi;
  } err_evt_t;

  // write-1-to-clear update where hardware set has priority
  function automatic logic [REG_W-1:0] w1c_next(input logic [REG_W-1:0] cur,
                                                 input logic [REG_W-1:0] clr,
                                                 input logic [REG_W-1:0] set);
    return (cur & ~clr) | set;
  endfunction

  // single-bit mask
  function automatic logic [REG_W-1:0] bit_mask(input int idx, input logic v);
    logic [REG_W-1:0] m;
    m = '0;
    m[idx] = v;
    return m;
  endfunction

  // external error is ours only if it lines up with our delayed address phase
  function automatic logic ext_attributed(input logic ap_delayed,
                                          input logic serr_line_n,
                                          input logic enable);
    return ap_delayed & ~serr_line_n & enable;
  endfunction

endpackage

// File: rtl/pci_err_cfg.sv
module pci_err_cfg
  import pci_err_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [2:0]       sel,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] cmd_q,
  output logic [REG_W-1:0] ena_q,
  output logic [REG_W-1:0] enb_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
      ena_q <= '0;
      enb_q <= '0;
    end else if (we) begin
      case (sel)
        REG_CMD: cmd_q <= wdata;
        REG_ENA: ena_q <= wdata;
        REG_ENB: enb_q <= wdata;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/pci_err_detect.sv
module pci_err_detect
  import pci_err_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int SERR_LAG = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_par_err,
  input  logic              data_par_err,
  input  logic              ext_serr_n,
  input  logic              own_addr_phase,
  input  logic [ADDR_W-1:0] pci_addr,
  input  logic              nmi_err,
  input  logic              par_resp_en,
  input  logic              serr_en,
  input  logic              ext_rep_en,
  input  logic              apar_rep_en,
  output err_evt_t          evt,
  output logic [ADDR_W-1:0] ext_addr
);

  localparam int LAST = SERR_LAG - 1;

  logic              ap_pipe   [SERR_LAG];
  logic [ADDR_W-1:0] addr_pipe [SERR_LAG];

  // delay line holding our address phases and their addresses
  generate
    for (genvar g = 0; g < SERR_LAG; g++) begin : g_lag
      if (g == 0) begin : g_head
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            ap_pipe[0]   <= 1'b0;
            addr_pipe[0] <= '0;
          end else begin
            ap_pipe[0]   <= own_addr_phase;
            addr_pipe[0] <= pci_addr;
          end
        end
      end else begin : g_tail
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            ap_pipe[g]   <= 1'b0;
            addr_pipe[g] <= '0;
          end else begin
            ap_pipe[g]   <= ap_pipe[g-1];
            addr_pipe[g] <= addr_pipe[g-1];
          end
        end
      end
    end
  endgenerate

  logic apar_act;

  always_comb begin
    apar_act        = addr_par_err & par_resp_en;
    evt.par_seen    = addr_par_err | data_par_err;
    evt.serr_drive  = apar_act & serr_en;
    evt.apar_report = apar_act & apar_rep_en;
    evt.ext_attr    = ext_attributed(ap_pipe[LAST], ext_serr_n, ext_rep_en);
    evt.nmi         = nmi_err;
  end

  assign ext_addr = addr_pipe[LAST];

  // R5: attribution needs the enable and a low sampled line
  assert_ext_needs_line_R5: assert property (@(posedge clk) disable iff (!rst_n)
    evt.ext_attr |-> (ext_rep_en && !ext_serr_n));

  // R2: the drive request never appears without a parity strobe
  assert_drive_from_apar_R2: assert property (@(posedge clk) disable iff (!rst_n)
    evt.serr_drive |-> addr_par_err);

endmodule

// File: rtl/pci_err_track.sv
module pci_err_track
  import pci_err_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [2:0]        sel,
  input  logic [REG_W-1:0]  wdata,
  input  err_evt_t          evt,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic [ADDR_W-1:0] pci_addr,
  input  logic              mc_en,
  input  logic              serr_en,
  output logic [REG_W-1:0]  sts_q,
  output logic [REG_W-1:0]  deta_q,
  output logic [REG_W-1:0]  detb_q,
  output logic [ADDR_W-1:0] eaddr_q,
  output logic              serr_n_q,
  output logic              mc_q
);

  logic [REG_W-1:0]  sts_clr, deta_clr, detb_clr;
  logic [REG_W-1:0]  sts_set, deta_set;
  logic [REG_W-1:0]  detb_d;
  logic [ADDR_W-1:0] eaddr_d;
  logic              lock, pci_err, capture, nmi_mark;

  always_comb begin
    sts_clr  = (we && sel == REG_STS)  ? wdata : '0;
    deta_clr = (we && sel == REG_DETA) ? wdata : '0;
    detb_clr = (we && sel == REG_DETB) ? wdata : '0;

    sts_set  = bit_mask(STS_DET_PAR, evt.par_seen)
             | bit_mask(STS_SIG_SERR, evt.serr_drive);
    deta_set = bit_mask(DETA_EXT_SERR, evt.ext_attr)
             | bit_mask(DETA_APAR, evt.apar_report)
             | bit_mask(DETA_NMI, evt.nmi);

    lock     = deta_q[DETA_EXT_SERR] | deta_q[DETA_APAR] | deta_q[DETA_NMI];
    pci_err  = evt.apar_report | evt.ext_attr;
    capture  = pci_err & ~lock;
    nmi_mark = evt.nmi & ~lock & ~pci_err;

    // the older address phase wins a same-cycle collision
    eaddr_d = eaddr_q;
    if (capture) eaddr_d = evt.ext_attr ? ext_addr : pci_addr;

    detb_d = w1c_next(detb_q, detb_clr, '0);
    if (capture)  detb_d[DETB_ADDR_BAD] = 1'b0;
    if (nmi_mark) detb_d[DETB_ADDR_BAD] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q    <= '0;
      deta_q   <= '0;
      detb_q   <= '0;
      eaddr_q  <= '0;
      serr_n_q <= 1'b1;
      mc_q     <= 1'b0;
    end else begin
      sts_q    <= w1c_next(sts_q, sts_clr, sts_set);
      deta_q   <= w1c_next(deta_q, deta_clr, deta_set);
      detb_q   <= detb_d;
      eaddr_q  <= eaddr_d;
      serr_n_q <= ~evt.serr_drive;
      mc_q     <= mc_en & pci_err;
    end
  end

  // R1: any parity strobe leaves the parity-seen bit set
  assert_par_status_R1: assert property (@(posedge clk) disable iff (!rst_n)
    evt.par_seen |=> sts_q[STS_DET_PAR]);

  // R2: SERR only when the command enable was set
  assert_serr_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !serr_n_q |-> $past(serr_en));

  // R3: driving SERR always shows in the status register
  assert_sig_serr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !serr_n_q |-> sts_q[STS_SIG_SERR]);

  // R6: machine check obeys the global enable
  assert_mc_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mc_q |-> $past(mc_en));

  // R8: NMI with nothing held marks the address invalid
  assert_nmi_marks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.nmi && !lock && !pci_err) |=> detb_q[DETB_ADDR_BAD]);

  // R9: held address does not move
  assert_addr_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> $stable(eaddr_q));

endmodule

// File: rtl/pci_err_report.sv
module pci_err_report
  import pci_err_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int SERR_LAG = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [15:0]       cfg_wdata,
  output logic [ADDR_W-1:0] cfg_rdata,
  input  logic              addr_par_err,
  input  logic              data_par_err,
  input  logic              ext_serr_n,
  input  logic              own_addr_phase,
  input  logic [ADDR_W-1:0] pci_addr,
  input  logic              nmi_err,
  input  logic              mc_en,
  output logic              serr_n,
  output logic              mc_req
);

  logic [REG_W-1:0]  cmd_q, ena_q, enb_q, sts_q, deta_q, detb_q;
  logic [ADDR_W-1:0] eaddr_q, ext_addr;
  err_evt_t          evt;

  pci_err_cfg u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .sel   (cfg_sel),
    .wdata (cfg_wdata),
    .cmd_q (cmd_q),
    .ena_q (ena_q),
    .enb_q (enb_q)
  );

  pci_err_detect #(.ADDR_W(ADDR_W), .SERR_LAG(SERR_LAG)) u_detect (
    .clk            (clk),
    .rst_n          (rst_n),
    .addr_par_err   (addr_par_err),
    .data_par_err   (data_par_err),
    .ext_serr_n     (ext_serr_n),
    .own_addr_phase (own_addr_phase),
    .pci_addr       (pci_addr),
    .nmi_err        (nmi_err),
    .par_resp_en    (cmd_q[CMD_PAR_RESP]),
    .serr_en        (cmd_q[CMD_SERR_EN]),
    .ext_rep_en     (ena_q[ENA_EXT_SERR]),
    .apar_rep_en    (enb_q[ENB_APAR]),
    .evt            (evt),
    .ext_addr       (ext_addr)
  );

  pci_err_track #(.ADDR_W(ADDR_W)) u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (cfg_we),
    .sel      (cfg_sel),
    .wdata    (cfg_wdata),
    .evt      (evt),
    .ext_addr (ext_addr),
    .pci_addr (pci_addr),
    .mc_en    (mc_en),
    .serr_en  (cmd_q[CMD_SERR_EN]),
    .sts_q    (sts_q),
    .deta_q   (deta_q),
    .detb_q   (detb_q),
    .eaddr_q  (eaddr_q),
    .serr_n_q (serr_n),
    .mc_q     (mc_req)
  );

  always_comb begin
    case (cfg_sel)
      REG_CMD:   cfg_rdata = ADDR_W'(cmd_q);
      REG_STS:   cfg_rdata = ADDR_W'(sts_q);
      REG_ENA:   cfg_rdata = ADDR_W'(ena_q);
      REG_ENB:   cfg_rdata = ADDR_W'(enb_q);
      REG_DETA:  cfg_rdata = ADDR_W'(deta_q);
      REG_DETB:  cfg_rdata = ADDR_W'(detb_q);
      REG_EADDR: cfg_rdata = eaddr_q;
      default:   cfg_rdata = '0;
    endcase
  end

  // R12: outputs idle right after reset release
  assert_idle_after_reset_R12: assert property (@(posedge clk)
    $rose(rst_n) |-> (serr_n && !mc_req));

endmodule

// File: tb/pci_err_report_tb.sv
`timescale 1ns/1ps
module pci_err_report_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = 3'd0;
  logic [15:0] cfg_wdata = 16'h0;
  logic [31:0] cfg_rdata;
  logic        addr_par_err = 1'b0, data_par_err = 1'b0;
  logic        ext_serr_n = 1'b1, own_addr_phase = 1'b0;
  logic [31:0] pci_addr = 32'h0;
  logic        nmi_err = 1'b0, mc_en = 1'b0;
  logic        serr_n, mc_req;
  int          n_checks = 0, n_fail = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  pci_err_report u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .addr_par_err(addr_par_err), .data_par_err(data_par_err),
    .ext_serr_n(ext_serr_n), .own_addr_phase(own_addr_phase),
    .pci_addr(pci_addr), .nmi_err(nmi_err), .mc_en(mc_en),
    .serr_n(serr_n), .mc_req(mc_req)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] sel, output logic [31:0] v);
    cfg_sel = sel;
    #1 v = cfg_rdata;
  endtask

  task automatic clear_all();
    wr(3'd1, 16'hFFFF);
    wr(3'd4, 16'hFFFF);
    wr(3'd5, 16'hFFFF);
  endtask

  // one-clock pulse of address parity with an address
  task automatic apar_pulse(input logic [31:0] a);
    @(negedge clk);
    addr_par_err = 1'b1; pci_addr = a;
    @(negedge clk);
    addr_par_err = 1'b0; pci_addr = 32'h0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int s = 0; s < 7; s++) begin
      rd(3'(s), v);
      check(v == 0, "R12 register reset", v, 0);
    end
    check(serr_n == 1'b1 && mc_req == 1'b0, "R12 outputs reset",
          {30'b0, serr_n, mc_req}, 32'h2);
  endtask

  task automatic t_parity_status();
    logic [31:0] v;
    wr(3'd0, 16'h0000);
    @(negedge clk); data_par_err = 1'b1;
    @(negedge clk); data_par_err = 1'b0;
    check(serr_n == 1'b1, "R2 no SERR on data parity", serr_n, 1);
    rd(3'd1, v);
    check(v[15] == 1'b1, "R1 data parity seen, cmd zero", v, 32'h8000);
    clear_all();
    apar_pulse(32'h11);
    check(serr_n == 1'b1, "R2 no SERR with cmd clear", serr_n, 1);
    rd(3'd1, v);
    check(v == 32'h8000, "R1 address parity seen, cmd zero", v, 32'h8000);
    clear_all();
  endtask

  task automatic t_serr_drive();
    logic [31:0] v;
    wr(3'd0, 16'h0040);
    apar_pulse(32'h22);
    check(serr_n == 1'b1, "R2 no SERR without bit 8", serr_n, 1);
    wr(3'd0, 16'h0100);
    apar_pulse(32'h23);
    check(serr_n == 1'b1, "R2 no SERR without bit 6", serr_n, 1);
    clear_all();
    wr(3'd0, 16'h0140);
    apar_pulse(32'h24);
    check(serr_n == 1'b0, "R2 SERR driven", serr_n, 0);
    rd(3'd1, v);
    check(v == 32'hC000, "R3 signalled bit set", v, 32'hC000);
    @(negedge clk);
    check(serr_n == 1'b1, "R2 SERR lasts one clock", serr_n, 1);
    wr(3'd0, 16'h0000);
    clear_all();
  endtask

  task automatic t_apar_report();
    logic [31:0] v;
    mc_en = 1'b1;
    wr(3'd3, 16'h0080);
    apar_pulse(32'h30);
    check(mc_req == 1'b0, "R4 no report without cmd bit 6", mc_req, 0);
    rd(3'd4, v);
    check(v == 0, "R4 detect stays clear", v, 0);
    wr(3'd0, 16'h0040);
    apar_pulse(32'hA000_0040);
    check(mc_req == 1'b1, "R4 machine check", mc_req, 1);
    @(negedge clk);
    check(mc_req == 1'b0, "R6 single-cycle pulse", mc_req, 0);
    rd(3'd4, v);
    check(v == 32'h40, "R4 detect bit 6", v, 32'h40);
    rd(3'd6, v);
    check(v == 32'hA000_0040, "R7 address captured", v, 32'hA000_0040);
    rd(3'd5, v);
    check(v[7] == 1'b0, "R7 address valid", v, 0);
    clear_all();
    mc_en = 1'b0;
    apar_pulse(32'h31);
    check(mc_req == 1'b0, "R6 global enable off", mc_req, 0);
    rd(3'd4, v);
    check(v == 32'h40, "R6 detect still records", v, 32'h40);
    clear_all();
    wr(3'd0, 16'h0000); wr(3'd3, 16'h0000);
  endtask

  // SERR sampled k edges after the edge that sampled our address phase
  task automatic ext_try(input int k, input logic [31:0] a);
    @(negedge clk);
    own_addr_phase = 1'b1; pci_addr = a;
    @(negedge clk);
    own_addr_phase = 1'b0; pci_addr = 32'hDEAD_0000;
    for (int i = 1; i < k; i++) @(negedge clk);
    ext_serr_n = 1'b0;
    @(negedge clk);
    ext_serr_n = 1'b1;
  endtask

  task automatic t_ext_window();
    logic [31:0] v;
    mc_en = 1'b1;
    wr(3'd2, 16'h0080);
    ext_try(1, 32'h100);
    check(mc_req == 1'b0, "R5 offset 1 ignored", mc_req, 0);
    rd(3'd4, v);
    check(v == 0, "R5 offset 1 no detect", v, 0);
    ext_try(3, 32'h300);
    check(mc_req == 1'b0, "R5 offset 3 ignored", mc_req, 0);
    rd(3'd4, v);
    check(v == 0, "R5 offset 3 no detect", v, 0);
    ext_try(2, 32'h200);
    check(mc_req == 1'b1, "R5 offset 2 machine check", mc_req, 1);
    rd(3'd4, v);
    check(v == 32'h80, "R5 detect bit 7", v, 32'h80);
    rd(3'd6, v);
    check(v == 32'h200, "R7 address-phase address", v, 32'h200);
    clear_all();
    wr(3'd2, 16'h0000);
    ext_try(2, 32'h400);
    check(mc_req == 1'b0, "R5 enable off", mc_req, 0);
    rd(3'd4, v);
    check(v == 0, "R5 enable off no detect", v, 0);
    mc_en = 1'b0;
  endtask

  task automatic t_nmi_and_freeze();
    logic [31:0] v;
    wr(3'd0, 16'h0040); wr(3'd3, 16'h0080);
    apar_pulse(32'h5000);
    clear_all();
    rd(3'd6, v);
    check(v == 32'h5000, "R7 seed address", v, 32'h5000);
    @(negedge clk); nmi_err = 1'b1;
    @(negedge clk); nmi_err = 1'b0;
    rd(3'd4, v);
    check(v == 32'h20, "R8 NMI detect", v, 32'h20);
    rd(3'd5, v);
    check(v == 32'h80, "R8 address invalid", v, 32'h80);
    rd(3'd6, v);
    check(v == 32'h5000, "R8 address kept", v, 32'h5000);
    apar_pulse(32'h6000);
    rd(3'd6, v);
    check(v == 32'h5000, "R9 frozen while held", v, 32'h5000);
    rd(3'd5, v);
    check(v == 32'h80, "R9 invalid flag kept", v, 32'h80);
    wr(3'd4, 16'hFFFF);
    apar_pulse(32'h7000);
    rd(3'd6, v);
    check(v == 32'h7000, "R9 released capture", v, 32'h7000);
    rd(3'd5, v);
    check(v == 0, "R7 valid after release", v, 0);
    clear_all();
  endtask

  task automatic t_w1c_race();
    logic [31:0] v;
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 3'd1; cfg_wdata = 16'h8000; data_par_err = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0; data_par_err = 1'b0;
    rd(3'd1, v);
    check(v == 32'h8000, "R10 set beats clear", v, 32'h8000);
    wr(3'd1, 16'h8000);
    rd(3'd1, v);
    check(v == 0, "R10 write one clears", v, 0);
  endtask

  task automatic t_collision();
    logic [31:0] v;
    mc_en = 1'b1;
    wr(3'd0, 16'h0040); wr(3'd2, 16'h0080); wr(3'd3, 16'h0080);
    @(negedge clk); own_addr_phase = 1'b1; pci_addr = 32'hAAAA;
    @(negedge clk); own_addr_phase = 1'b0; pci_addr = 32'h0;
    @(negedge clk);
    ext_serr_n = 1'b0; addr_par_err = 1'b1; pci_addr = 32'hBBBB;
    @(negedge clk);
    ext_serr_n = 1'b1; addr_par_err = 1'b0; pci_addr = 32'h0;
    check(mc_req == 1'b1, "R11 pulse present", mc_req, 1);
    @(negedge clk);
    check(mc_req == 1'b0, "R11 single pulse", mc_req, 0);
    rd(3'd4, v);
    check(v == 32'hC0, "R11 both detect bits", v, 32'hC0);
    rd(3'd6, v);
    check(v == 32'hAAAA, "R11 older address wins", v, 32'hAAAA);
    mc_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_parity_status();
    t_serr_drive();
    t_apar_report();
    t_ext_window();
    t_nmi_and_freeze();
    t_w1c_race();
    t_collision();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule